// File: doc/BRIEF.md
# Latched Seven-Segment Digit Strober

This block writes six BCD digits into six external seven-segment latches that share one segment bus. Each latch has its own enable strobe. The block works through the digits in a fixed rotation. For each digit it encodes the value into segment code, puts that code on the shared bus for one tick with every strobe low, and then raises only that digit's strobe for one tick while the bus holds still. The latches keep their contents between writes, so the display is static and never scanned. Every digit is rewritten once per 12-tick frame.

The block runs on a slow system tick, such as a mains-derived clock. The time-keeping logic upstream supplies the six digits as one packed vector, with hours tens in the top nibble. A parameter selects segment polarity, for common-cathode or common-anode displays.

Top module: `seg_latch_strober`

## Requirements
- R1: With `ACTIVE_LOW=0`, the segment bus carries segment a on bit 6 down to segment g on bit 0. A 1 lights a segment. The codes for digits 0 to 9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F and 7B (hex).
- R2: A digit value of 10 to 15 is shown blank: code 00 with the default polarity.
- R3: With `ACTIVE_LOW=1`, every bus bit is the inverse of the R1/R2 code. Blank is then 7F.
- R4: Each digit takes two ticks. On the setup tick, the new code appears on the bus and all strobes are low. On the next tick, that digit's strobe is high for exactly one tick.
- R5: Digits are written in the order hours tens, hours ones, minutes tens, minutes ones, seconds tens, seconds ones, and the rotation then wraps. `digitsIn[23:20]` is hours tens and `digitsIn[3:0]` is seconds ones. `strobe[5]` is hours tens and `strobe[0]` is seconds ones. The frame is 12 ticks long.
- R6: At most one strobe is high at any time.
- R7: The bus does not change while a strobe is high. A change on `digitsIn` during a strobe tick has no effect on the bus until the next setup tick.
- R8: While `rstN` is low, all strobes are low and the bus shows blank. The first tick after release is the setup tick for hours tens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| digitsIn | input | 24 | Six packed BCD digits, hours tens in the top nibble |
| segBus | output | 7 | Shared segment bus, a on bit 6 down to g on bit 0 |
| strobe | output | 6 | Active-high latch enables, hours tens on bit 5 |

## Verification
The bench builds two copies side by side. One uses the default `ACTIVE_LOW=0` and the other uses `ACTIVE_LOW=1`, and both are fed the same digits. Every code, including blank, is therefore checked in both polarities on the same tick. The default six-digit width lets a whole frame be compared tick by tick against the stated order and codes. It also allows directed checks of mid-strobe input changes and of a reset asserted in the middle of a frame.

// File: rtl/strober_pkg.sv
package strober_pkg;
  localparam int SEL_W = 4;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef struct packed {
    logic             load;
    logic             fire;
    logic [SEL_W-1:0] sel;
  } strobe_ctl_t;

  // Active-high code, segment a in bit 6 through g in bit 0
  function automatic logic [SEG_W-1:0] bcdToSeg(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] code;
    case (v)
      4'd0:    code = 7'h7E;
      4'd1:    code = 7'h30;
      4'd2:    code = 7'h6D;
      4'd3:    code = 7'h79;
      4'd4:    code = 7'h33;
      4'd5:    code = 7'h5B;
      4'd6:    code = 7'h5F;
      4'd7:    code = 7'h70;
      4'd8:    code = 7'h7F;
      4'd9:    code = 7'h7B;
      default: code = 7'h00;
    endcase
    return code;
  endfunction
endpackage

// File: rtl/strober_ctrl.sv
module strober_ctrl
  import strober_pkg::*;
#(
  parameter int NUM_DIGITS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  output strobe_ctl_t ctl
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_DIGITS - 1);

  logic             phase;   // 0 = setup tick, 1 = strobe tick
  logic [SEL_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 1'b0;
      idx   <= '0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        idx <= (idx == LAST_IDX) ? '0 : SEL_W'(idx + 1'b1);
      end
    end
  end

  always_comb begin
    ctl.load = ~phase;
    ctl.fire = phase;
    ctl.sel  = idx;
  end
endmodule

// File: rtl/strober_dpath.sv
module strober_dpath
  import strober_pkg::*;
#(
  parameter int NUM_DIGITS = 6,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_DIGITS*BCD_W-1:0] digitsIn,
  input  strobe_ctl_t                 ctl,
  output logic [SEG_W-1:0]            segBus,
  output logic [NUM_DIGITS-1:0]       strobe
);
  logic [SEG_W-1:0] polMask;
  logic [BCD_W-1:0] digitArr [NUM_DIGITS];
  logic [BCD_W-1:0] picked;
  logic [NUM_DIGITS-1:0] strobeNext;

  generate
    if (ACTIVE_LOW) begin : g_polLow
      assign polMask = '1;
    end else begin : g_polHigh
      assign polMask = '0;
    end

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_unpack
      assign digitArr[i] = digitsIn[(NUM_DIGITS-1-i)*BCD_W +: BCD_W];
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (ctl.sel == SEL_W'(i)) picked = digitArr[i];
    end
  end

  always_comb begin
    strobeNext = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      strobeNext[NUM_DIGITS-1-i] = ctl.fire && (ctl.sel == SEL_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segBus <= polMask;
      strobe <= '0;
    end else begin
      if (ctl.load) segBus <= bcdToSeg(picked) ^ polMask;
      strobe <= strobeNext;
    end
  end
endmodule

// File: rtl/seg_latch_strober.sv
module seg_latch_strober
  import strober_pkg::*;
#(
  parameter int NUM_DIGITS = 6,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_DIGITS*BCD_W-1:0] digitsIn,
  output logic [SEG_W-1:0]            segBus,
  output logic [NUM_DIGITS-1:0]       strobe
);
  strobe_ctl_t ctl;

  strober_ctrl #(.NUM_DIGITS(NUM_DIGITS)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl)
  );

  strober_dpath #(.NUM_DIGITS(NUM_DIGITS), .ACTIVE_LOW(ACTIVE_LOW)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .digitsIn (digitsIn),
    .ctl      (ctl),
    .segBus   (segBus),
    .strobe   (strobe)
  );
endmodule

// File: rtl/strober_chk.sv
module strober_chk #(
  parameter int NUM_DIGITS = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [6:0]            segBus,
  input logic [NUM_DIGITS-1:0] strobe
);
  logic [NUM_DIGITS-1:0] nextExp;

  always_comb begin
    if (strobe[0]) nextExp = {1'b1, {(NUM_DIGITS-1){1'b0}}};
    else           nextExp = strobe >> 1;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R6

  AST_QUIET_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (strobe == '0)); // R8

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != '0) |-> $stable(segBus)); // R7

  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != '0) |=> (strobe == '0)); // R4

  AST_ROTATION: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != '0) |=> ##1 (strobe == $past(nextExp, 2))); // R5
endmodule

bind seg_latch_strober strober_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .segBus (segBus),
  .strobe (strobe)
);

// File: tb/seg_latch_strober_tb.sv
module seg_latch_strober_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] digits;
  logic [6:0]  segHi, segLo;
  logic [5:0]  strHi, strLo;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_latch_strober #(.NUM_DIGITS(6), .ACTIVE_LOW(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .digitsIn(digits), .segBus(segHi), .strobe(strHi));

  seg_latch_strober #(.NUM_DIGITS(6), .ACTIVE_LOW(1'b1)) dutLow_i (
    .clk(clk), .rstN(rstN), .digitsIn(digits), .segBus(segLo), .strobe(strLo));

  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h012345, 24'h678901, 24'h6789AB, 24'hCDEF90, 24'h235959, 24'h000000};

  function automatic logic [6:0] expSeg(input logic [3:0] v);
    case (v)
      4'd0: return 7'h7E;  4'd1: return 7'h30;  4'd2: return 7'h6D;
      4'd3: return 7'h79;  4'd4: return 7'h33;  4'd5: return 7'h5B;
      4'd6: return 7'h5F;  4'd7: return 7'h70;  4'd8: return 7'h7F;
      4'd9: return 7'h7B;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [23:0] d);
    for (int k = 0; k < 6; k++) begin
      logic [3:0] v;
      logic [6:0] e;
      v = d[(5-k)*4 +: 4];
      e = expSeg(v);
      tick();
      check((v > 4'd9) ? "R2 blank high" : "R1 code", segHi, e);
      check("R3 inverted", segLo, ~e);
      check("R4 setup strobes low", {1'b0, strHi}, 7'h00);
      check("R4 setup strobes low (low pol)", {1'b0, strLo}, 7'h00);
      tick();
      check("R7 bus held", segHi, e);
      check("R5 order", {1'b0, strHi}, {1'b0, 6'b1 << (5-k)});
      check("R6 one strobe (low pol)", {1'b0, strLo}, {1'b0, 6'b1 << (5-k)});
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b1;
    digits = 24'h123456;
    #1 rstN = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 reset blank", segHi, 7'h00);
    check("R8 reset blank low pol", segLo, 7'h7F);
    check("R8 reset strobes", {1'b0, strHi}, 7'h00);
    digits = 24'h888888;
    tick();
    tick();
    check("R8 held in reset", segHi, 7'h00);
    check("R8 held strobes", {1'b0, strHi | strLo}, 7'h00);
    rstN = 1'b1;

    // Table walk
    for (int n = 0; n < NVEC; n++) begin
      digits = VEC[n];
      runFrame(VEC[n]);
    end

    // R7: digit change during strobe tick does not reach the bus
    digits = 24'h111111;
    tick();
    check("R7 setup", segHi, 7'h30);
    digits = 24'h888888;
    tick();
    check("R7 ignore mid-strobe change", segHi, 7'h30);
    check("R7 strobe Ht", {1'b0, strHi}, 7'h20);
    tick();
    check("R7 next setup takes new value", segHi, 7'h7F);
    tick();
    check("R5 strobe Ho", {1'b0, strHi}, 7'h10);
    tick();

    // R8: reset in mid-frame, restart at hours tens
    rstN = 1'b0;
    #1;
    check("R8 mid-frame reset strobes", {1'b0, strHi | strLo}, 7'h00);
    check("R8 mid-frame reset blank", segHi, 7'h00);
    @(negedge clk);
    rstN = 1'b1;
    digits = 24'h987654;
    runFrame(24'h987654);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule